// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block is the host-side master for a multi-channel serial ADC that samples all of its inputs at the same instant. When a start request is accepted, the controller latches a 3-bit channel-count code and uses the current polarity mode. It drives a convert-start pulse, which freezes every analog input at once. It then toggles a serial clock for one 16-clock frame per active channel. While that clock runs it shifts in the data line and delivers one 12-bit result per channel. Each result comes with its channel index, a one-cycle valid strobe and a flag that tells whether the word is two's complement or straight binary.

The serial clock runs at the system clock divided by `2*HALF_DIV` and rests low between conversions. The ADC updates its data line on the rising serial-clock edge, so the controller samples on the falling edge. Changes on the select and mode inputs are ignored from acceptance until the last frame has been read. If the mode input no longer matches the mode of the last conversion, the controller holds `busy_o` high for `ACQ_CYC` system clocks. This gives the analog inputs time to settle before the next start can be accepted.

Top module: `ssadc_ctrl`

## Requirements
- R1: Select codes 0 to 4 read out code+1 channels, delivered in index order 0, 1, 2, and so on, with `res_chan_o` equal to the index.
- R2: Select codes 5, 6 and 7 read out all six channels (indices 0 to 5). No result carries an index above 5.
- R3: Each active channel gets exactly 16 rising edges of `sck_o`. `sck_o` and `conv_o` are low whenever `busy_o` is low.
- R4: `conv_o` goes high on acceptance and stays high for one serial-clock period (`2*HALF_DIV` system clocks) with `sck_o` low. `conv_o` and `sck_o` are never high together.
- R5: Data is sampled on falling `sck_o` edges. Number the frame bits 0 to 15 in transmission order. Bits 2 to 13 form the result, with bit 2 as the MSB; bits 0, 1, 14 and 15 are discarded.
- R6: `res_signed_o` is 1 (two's complement) for a bipolar conversion and 0 (straight binary) for a unipolar one.
- R7: A start is accepted only when `start_i` is high and `busy_o` is low. `busy_o` stays high until the last frame has been read, and starts that arrive in that time are ignored.
- R8: Changes on `sel_i` or `bipolar_i` after acceptance do not change that conversion's channel count or result flag.
- R9: While idle, a `bipolar_i` value that differs from the last conversion's mode (unipolar after reset) holds `busy_o` high for `ACQ_CYC` system clocks. No conversion starts during that time.
- R10: `res_valid_o` is a single-cycle pulse per channel, and `res_data_o`, `res_chan_o` and `res_signed_o` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| sel_i | input | 3 | Channel-count code |
| bipolar_i | input | 1 | 1 = bipolar input range, 0 = unipolar |
| sdi_i | input | 1 | Serial data from the ADC |
| busy_o | output | 1 | Conversion in progress or acquisition wait |
| conv_o | output | 1 | Convert-start pulse to the ADC |
| sck_o | output | 1 | Serial clock to the ADC |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 12 | Channel result |
| res_chan_o | output | 3 | Channel index of the result |
| res_signed_o | output | 1 | 1 = result is two's complement |

## Verification
The hardest case to reach is a mode or select change in the middle of a readout. The bench has to prove that the running conversion keeps its latched count and flag, and that the acquisition wait begins only once the controller is idle again. One scenario starts a two-channel conversion and waits for the first serial-clock edges. It then moves the select code to 7 and flips the mode bit. It checks that exactly two results appear with the original flag, and that `busy_o` stays high through the wait that follows. A separate scenario flips the mode while idle, issues a start inside the wait, and counts the busy cycles and convert pulses.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int RES_BITS   = 12;
  localparam int LEAD_BITS  = 2;
  localparam int MAX_CH     = 6;
  localparam int CH_W       = $clog2(MAX_CH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_SHIFT} ctrl_state_e;

  // codes at or above MAX_CH-1 saturate to all channels
  function automatic logic [CH_W-1:0] chan_count(input logic [2:0] code);
    if (int'(code) >= MAX_CH - 1) return CH_W'(MAX_CH);
    return CH_W'(code) + CH_W'(1);
  endfunction
endpackage

// File: rtl/ssadc_sck_gen.sv
module ssadc_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/ssadc_acq_guard.sv
module ssadc_acq_guard #(
  parameter int ACQ_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic mode_i,
  output logic mode_o,
  output logic wait_o
);
  localparam int AW = $clog2(ACQ_CYC + 1);

  logic          mode_q;
  logic [AW-1:0] cnt_q;

  assign mode_o = mode_q;
  assign wait_o = (mode_i != mode_q);

  // mode_q only moves while idle, so a running conversion keeps its mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (idle_i && wait_o) begin
      if (cnt_q == AW'(ACQ_CYC - 1)) begin
        mode_q <= mode_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + AW'(1);
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/ssadc_deser.sv
module ssadc_deser
  import ssadc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic                sdi_i,
  output logic [RES_BITS-1:0] word_o
);
  logic [RES_BITS-1:0] sh_q;

  assign word_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (take_i) sh_q <= {sh_q[RES_BITS-2:0], sdi_i};
  end
endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl
  import ssadc_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ACQ_CYC  = 50
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          sel_i,
  input  logic                bipolar_i,
  input  logic                sdi_i,
  output logic                busy_o,
  output logic                conv_o,
  output logic                sck_o,
  output logic                res_valid_o,
  output logic [RES_BITS-1:0] res_data_o,
  output logic [2:0]          res_chan_o,
  output logic                res_signed_o
);
  localparam int FB_W   = $clog2(FRAME_BITS);
  localparam int BCNT_W = $clog2(MAX_CH * FRAME_BITS);

  ctrl_state_e         state_q;
  logic                conv_q, sck_q, phase_q;
  logic [CH_W-1:0]     nch_q;
  logic [BCNT_W-1:0]   bit_q, last_idx;
  logic [2:0]          chan_q;
  logic                valid_q, signed_q;
  logic [RES_BITS-1:0] data_q;
  logic [2:0]          rchan_q;

  logic                tick, idle, acq_wait, mode_cur, accept, smp, take, frame_end, last_bit;
  logic [FB_W-1:0]     pos;
  logic [RES_BITS-1:0] word;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && start_i && !acq_wait;
  assign smp       = (state_q == ST_SHIFT) && tick && sck_q;
  assign pos       = bit_q[FB_W-1:0];
  assign take      = smp && (int'(pos) >= LEAD_BITS) && (int'(pos) < LEAD_BITS + RES_BITS);
  assign frame_end = smp && (pos == FB_W'(FRAME_BITS - 1));
  assign last_idx  = (BCNT_W'(nch_q) << FB_W) - BCNT_W'(1);
  assign last_bit  = (bit_q == last_idx);

  ssadc_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!idle),
    .tick_o(tick)
  );

  ssadc_acq_guard #(.ACQ_CYC(ACQ_CYC)) u_acq_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idle_i(idle),
    .mode_i(bipolar_i),
    .mode_o(mode_cur),
    .wait_o(acq_wait)
  );

  ssadc_deser u_deser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .sdi_i (sdi_i),
    .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      conv_q   <= 1'b0;
      sck_q    <= 1'b0;
      phase_q  <= 1'b0;
      nch_q    <= '0;
      bit_q    <= '0;
      chan_q   <= '0;
      valid_q  <= 1'b0;
      signed_q <= 1'b0;
      data_q   <= '0;
      rchan_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          nch_q   <= chan_count(sel_i);
          conv_q  <= 1'b1;
          phase_q <= 1'b0;
          bit_q   <= '0;
          chan_q  <= '0;
          sck_q   <= 1'b0;
          state_q <= ST_CONV;
        end
        ST_CONV: if (tick) begin
          // convert pulse spans two half periods
          if (!phase_q) phase_q <= 1'b1;
          else begin
            conv_q  <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!sck_q) sck_q <= 1'b1;
          else begin
            sck_q <= 1'b0;
            bit_q <= bit_q + BCNT_W'(1);
            if (frame_end) begin
              valid_q  <= 1'b1;
              data_q   <= word;
              rchan_q  <= chan_q;
              signed_q <= mode_cur;
              chan_q   <= chan_q + 3'd1;
            end
            if (last_bit) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = !idle || acq_wait;
  assign conv_o       = conv_q;
  assign sck_o        = sck_q;
  assign res_valid_o  = valid_q;
  assign res_data_o   = data_q;
  assign res_chan_o   = rchan_q;
  assign res_signed_o = signed_q;
endmodule

// File: rtl/ssadc_ctrl_chk.sv
module ssadc_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       conv_o,
  input logic       sck_o,
  input logic       res_valid_o,
  input logic [2:0] res_chan_o
);
  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !conv_o));

  assert_sck_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> busy_o);

  assert_conv_sck_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_o && sck_o));

  assert_conv_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> $past(start_i && !busy_o));

  assert_chan_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_chan_o < 3'd6));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

bind ssadc_ctrl ssadc_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .conv_o     (conv_o),
  .sck_o      (sck_o),
  .res_valid_o(res_valid_o),
  .res_chan_o (res_chan_o)
);

// File: tb/ssadc_ctrl_tb.sv
module ssadc_ctrl_tb;
  localparam int HALF = 2;
  localparam int ACQ  = 20;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, bipolar_i = 1'b0, sdi_i = 1'b0;
  logic [2:0]  sel_i = 3'd0;
  logic        busy_o, conv_o, sck_o, res_valid_o, res_signed_o;
  logic [11:0] res_data_o;
  logic [2:0]  res_chan_o;

  int n_chk = 0, n_bad = 0;

  ssadc_ctrl #(.HALF_DIV(HALF), .ACQ_CYC(ACQ)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [11:0] chval(input int seed, input int ch);
    return 12'((seed * 397 + ch * 1187 + 291) & 32'hFFF);
  endfunction

  // ADC model: drives frame bit on rising sck
  int seed_cur = 0, model_seed = 0, ptr = 0;
  always @(posedge conv_o) begin model_seed = seed_cur; ptr = 0; end
  always @(posedge sck_o) begin
    int ch, k;
    logic [11:0] v;
    ch = ptr / 16;
    k  = ptr % 16;
    v  = chval(model_seed, ch);
    sdi_i <= (k >= 2 && k <= 13) ? v[13 - k] : 1'b0;
    ptr++;
  end

  // monitors
  int sck_rises = 0, conv_rises = 0, conv_run = 0, conv_w = 0, n_res = 0, valid_cyc = 0;
  logic [11:0] r_data [8];
  logic [2:0]  r_chan [8];
  logic        r_sgn  [8];
  logic        conv_prev = 1'b0;
  always @(posedge sck_o) sck_rises++;
  always @(negedge clk_i) begin
    if (conv_o && !conv_prev) conv_rises++;
    conv_prev = conv_o;
    if (conv_o) conv_run++;
    else if (conv_run != 0) begin conv_w = conv_run; conv_run = 0; end
    if (res_valid_o) begin
      valid_cyc++;
      if (n_res < 8) begin
        r_data[n_res] = res_data_o;
        r_chan[n_res] = res_chan_o;
        r_sgn[n_res]  = res_signed_o;
      end
      n_res++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy_o; i++) @(negedge clk_i);
  endtask

  task automatic reset_check();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R3", "reset sck", int'(sck_o), 0);
    chk("R4", "reset conv", int'(conv_o), 0);
    chk("R7", "reset busy", int'(busy_o), 0);
    chk("R10", "reset valid", int'(res_valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // poke: 0 none, 1 second start mid-run, 2 change sel and mode mid-run
  task automatic run_conv(input int sel, input bit bip, input int seed, input int poke);
    int exp_n, cr0;
    exp_n = (sel >= 5) ? 6 : sel + 1;
    @(negedge clk_i);
    bipolar_i = bip;
    @(negedge clk_i);
    wait_idle();
    sel_i = 3'(sel);
    seed_cur = seed;
    n_res = 0; valid_cyc = 0; sck_rises = 0; cr0 = conv_rises;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7", "busy after start", int'(busy_o), 1);
    if (poke != 0) begin
      while (sck_rises < 3) @(negedge clk_i);
      if (poke == 1) begin
        start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
      end else begin
        sel_i = 3'd7; bipolar_i = ~bip;
      end
    end
    wait_idle();
    repeat (2) @(negedge clk_i);
    chk((sel >= 5) ? "R2" : "R1", $sformatf("sel %0d result count", sel), n_res, exp_n);
    chk("R10", "valid cycles", valid_cyc, exp_n);
    chk("R3", "sck rises", sck_rises, 16 * exp_n);
    chk("R4", "conv width", conv_w, 2 * HALF);
    chk("R7", "conv pulses", conv_rises - cr0, 1);
    for (int i = 0; i < exp_n && i < 8; i++) begin
      chk("R1", "chan index", int'(r_chan[i]), i);
      chk("R5", $sformatf("data ch%0d", i), int'(r_data[i]), int'(chval(seed, i)));
      chk((poke == 2) ? "R8" : "R6", "signed flag", int'(r_sgn[i]), int'(bip));
    end
  endtask

  task automatic acq_test();
    int cnt, cr0;
    wait_idle();
    @(negedge clk_i);
    cr0 = conv_rises;
    bipolar_i = ~bipolar_i;
    cnt = 0;
    #1;
    while (busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk_i);
      start_i = (cnt == 5);
      #1;
    end
    start_i = 1'b0;
    chk("R9", "acq busy cycles", cnt, ACQ);
    repeat (3) @(negedge clk_i);
    chk("R9", "no conv during wait", conv_rises - cr0, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    reset_check();
    for (int s = 0; s < 8; s++) run_conv(s, s[0], 11 + s * 7, 0);
    run_conv(0, 1'b0, 500, 1);
    run_conv(1, 1'b1, 777, 2);
    acq_test();
    acq_test();
    run_conv(5, bipolar_i, 1234, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule